// File: doc/BRIEF.md
# Buffered Four-Channel Input Capture Unit

The block timestamps edges on four input pins against a free-running 16-bit counter. Each channel has three parts:

- an edge detector on its pin;
- a capture register;
- an 8-bit edge counter (pulse accumulator).

Each channel can also copy its capture value and its edge count into a pair of holding registers. Those holding registers run in one of two modes:

- **Queue mode.** A new edge pushes the previous timestamp down into the holding register, so software can read two successive edge times.
- **Latch mode.** A software command snapshots every channel into its holding registers in the same clock cycle.

A small register port gives software the control bits, the latch command and the per-channel event flags, which clear on a write of one. It also gives read access to every register.

Software sets the edge type for each channel. It picks whether flags rise on every edge or only when a holding register is loaded in queue mode. It also picks whether the edge counters wrap or saturate.

Top module: `cap_buf_timer`

## Requirements
- R1: After reset, every register reads zero. The main counter at address 3 then increases by one each clock cycle.
- R2: The edge select at address 1 holds two bits per channel, at bits [2i+1:2i], with these codes:
  - 00 off;
  - 01 rising edge;
  - 10 falling edge;
  - 11 both edges.

  On a valid edge, the capture register (address 4+i) loads the main counter value. That value is the count read at address 3 in the cycle the pin changed, plus 2.
- R3: When the buffer enable (control bit 0 at address 0) is clear, no holding register changes. This holds for the capture holding registers (address 8+i) and for the count holding registers (address 16+i). A latch command has no effect in this state.
- R4: Queue mode is buffer enable set with the latch-mode bit (control bit 1) clear. In queue mode, the first edge on a channel after queue mode is entered only loads the capture register. Each later edge first moves the old capture value into the holding register, then loads the new one.
- R5: In latch mode, a write to address 0 with bit 4 set copies all four capture values into their holding registers in one cycle, and all four edge counts likewise. This requires buffer enable and latch mode to be already set. The same write clears the edge counters.
- R6: With the flag-mode bit (control bit 2) clear, each valid edge sets that channel's flag (bit i at address 2).
- R7: With flag mode set and queue mode active, a flag is set only when that channel's holding register is loaded. With flag mode set outside queue mode, flags behave as in R6.
- R8: Each edge counter (address 12+i) counts its channel's valid edges. Its behaviour at 0xFF depends on the saturate bit (control bit 3):
  - clear: the count wraps from 0xFF to 0x00;
  - set: the count stays at 0xFF.
- R9: Writing one to a flag bit at address 2 clears that flag. A set event in the same cycle wins over the clear.
- R10: Control bit 4 is a command bit and always reads back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 4 | Capture input pins, one per channel |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register address |
| wdata | input | 16 | Register write data |
| rdata | output | 16 | Register read data for addr, combinational |

## Verification
The hardest case to reach is a flag-clear write that lands on exactly the clock edge where an input edge sets the same flag. The synchronizer delay puts that edge three cycles after the pin moves. The bench moves the pin, lets two clock edges pass, and then issues the clear, so that both reach the flag register together.

Edge-counter wrap and saturation need hundreds of edges on one channel. Directed loops toggle a pin with both-edge select for that purpose. Random sequences of mode writes, latch commands, flag clears and pin changes are compared against a bench model after each step.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
  localparam int CTRL_ADDR = 0;
  localparam int ESEL_ADDR = 1;
  localparam int FLAG_ADDR = 2;
  localparam int CNT_ADDR  = 3;
  localparam int CAP_BASE  = 4;

  localparam int BIT_BUF  = 0;
  localparam int BIT_LAT  = 1;
  localparam int BIT_FM   = 2;
  localparam int BIT_SAT  = 3;
  localparam int BIT_LCMD = 4;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_sel_e;

  function automatic logic edge_hit(input logic [1:0] sel, input logic prev, input logic cur);
    case (edge_sel_e'(sel))
      EDGE_RISE: edge_hit = !prev && cur;
      EDGE_FALL: edge_hit = prev && !cur;
      EDGE_ANY:  edge_hit = prev ^ cur;
      default:   edge_hit = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/cbt_edge_det.sv
module cbt_edge_det
  import cbt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  logic [1:0] sel,
  output logic       hit
);
  logic s1_q, s2_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= pin;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign hit = edge_hit(sel, prev_q, s2_q);
endmodule

// File: rtl/cbt_channel.sv
module cbt_channel #(
  parameter int CW = 16,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit,
  input  logic [CW-1:0] cnt,
  input  logic          queue,
  input  logic          latch_go,
  input  logic          sat,
  output logic [CW-1:0] cap,
  output logic [CW-1:0] cap_hold,
  output logic [PW-1:0] pacc,
  output logic [PW-1:0] pacc_hold,
  output logic          hold_load
);
  localparam logic [PW-1:0] PMAX = {PW{1'b1}};

  logic full_q;

  function automatic logic [PW-1:0] pacc_step(input logic [PW-1:0] v, input logic s);
    if (s && v == PMAX) pacc_step = v;
    else                pacc_step = v + PW'(1);
  endfunction

  assign hold_load = queue && hit && full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= 1'b0;
    else if (!queue) full_q <= 1'b0;
    else if (hit) full_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap      <= '0;
      cap_hold <= '0;
    end else begin
      if (hold_load || latch_go) cap_hold <= cap;
      if (hit) cap <= cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pacc      <= '0;
      pacc_hold <= '0;
    end else if (latch_go) begin
      pacc_hold <= pacc;
      pacc      <= hit ? PW'(1) : '0;
    end else if (hit) begin
      pacc <= pacc_step(pacc, sat);
    end
  end
endmodule

// File: rtl/cbt_regs.sv
module cbt_regs
  import cbt_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = 16,
  parameter int PW  = 8,
  parameter int AW  = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [AW-1:0]           addr,
  input  logic [CW-1:0]           wdata,
  input  logic [NCH-1:0]          flag_set,
  input  logic [CW-1:0]           cnt,
  input  logic [NCH-1:0][CW-1:0]  cap,
  input  logic [NCH-1:0][CW-1:0]  cap_hold,
  input  logic [NCH-1:0][PW-1:0]  pacc,
  input  logic [NCH-1:0][PW-1:0]  pacc_hold,
  output logic                    buf_en,
  output logic                    latch_mode,
  output logic                    flag_mode,
  output logic                    sat_mode,
  output logic [2*NCH-1:0]        esel,
  output logic [NCH-1:0]          flags,
  output logic                    latch_go,
  output logic [CW-1:0]           rdata
);
  localparam int HOLD_BASE = CAP_BASE + NCH;
  localparam int PACC_BASE = CAP_BASE + 2 * NCH;
  localparam int PHLD_BASE = CAP_BASE + 3 * NCH;

  logic wr_ctrl, wr_esel, wr_flag;
  logic [NCH-1:0] flag_clr;

  assign wr_ctrl  = wr_en && addr == AW'(CTRL_ADDR);
  assign wr_esel  = wr_en && addr == AW'(ESEL_ADDR);
  assign wr_flag  = wr_en && addr == AW'(FLAG_ADDR);
  assign latch_go = wr_ctrl && wdata[BIT_LCMD] && buf_en && latch_mode;
  assign flag_clr = wr_flag ? wdata[NCH-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_en     <= 1'b0;
      latch_mode <= 1'b0;
      flag_mode  <= 1'b0;
      sat_mode   <= 1'b0;
      esel       <= '0;
      flags      <= '0;
    end else begin
      if (wr_ctrl) begin
        buf_en     <= wdata[BIT_BUF];
        latch_mode <= wdata[BIT_LAT];
        flag_mode  <= wdata[BIT_FM];
        sat_mode   <= wdata[BIT_SAT];
      end
      if (wr_esel) esel <= wdata[2*NCH-1:0];
      flags <= (flags & ~flag_clr) | flag_set;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == AW'(CTRL_ADDR)) begin
      rdata[BIT_BUF] = buf_en;
      rdata[BIT_LAT] = latch_mode;
      rdata[BIT_FM]  = flag_mode;
      rdata[BIT_SAT] = sat_mode;
    end
    if (addr == AW'(ESEL_ADDR)) rdata[2*NCH-1:0] = esel;
    if (addr == AW'(FLAG_ADDR)) rdata[NCH-1:0] = flags;
    if (addr == AW'(CNT_ADDR))  rdata = cnt;
    for (int i = 0; i < NCH; i++) begin
      if (addr == AW'(CAP_BASE + i))  rdata = cap[i];
      if (addr == AW'(HOLD_BASE + i)) rdata = cap_hold[i];
      if (addr == AW'(PACC_BASE + i)) rdata = CW'(pacc[i]);
      if (addr == AW'(PHLD_BASE + i)) rdata = CW'(pacc_hold[i]);
    end
  end
endmodule

// File: rtl/cap_buf_timer.sv
module cap_buf_timer
  import cbt_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = 16,
  parameter int PW  = 8,
  parameter int AW  = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] pin_in,
  input  logic           wr_en,
  input  logic [AW-1:0]  addr,
  input  logic [CW-1:0]  wdata,
  output logic [CW-1:0]  rdata
);
  logic [CW-1:0]          cnt_q;
  logic                   buf_en, latch_mode, flag_mode, sat_mode, latch_go;
  logic                   queue_on;
  logic [2*NCH-1:0]       esel;
  logic [NCH-1:0]         flags, hit, hold_load, flag_set;
  logic [NCH-1:0][CW-1:0] cap, cap_hold;
  logic [NCH-1:0][PW-1:0] pacc, pacc_hold;

  assign queue_on = buf_en && !latch_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + CW'(1);
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    cbt_edge_det u_edge (
      .clk(clk), .rst_n(rst_n), .pin(pin_in[i]),
      .sel(esel[2*i+1:2*i]), .hit(hit[i])
    );
    cbt_channel #(.CW(CW), .PW(PW)) u_chan (
      .clk(clk), .rst_n(rst_n), .hit(hit[i]), .cnt(cnt_q),
      .queue(queue_on), .latch_go(latch_go), .sat(sat_mode),
      .cap(cap[i]), .cap_hold(cap_hold[i]), .pacc(pacc[i]),
      .pacc_hold(pacc_hold[i]), .hold_load(hold_load[i])
    );
    assign flag_set[i] = (flag_mode && queue_on) ? hold_load[i] : hit[i];
  end

  cbt_regs #(.NCH(NCH), .CW(CW), .PW(PW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .flag_set(flag_set), .cnt(cnt_q), .cap(cap), .cap_hold(cap_hold),
    .pacc(pacc), .pacc_hold(pacc_hold), .buf_en(buf_en),
    .latch_mode(latch_mode), .flag_mode(flag_mode), .sat_mode(sat_mode),
    .esel(esel), .flags(flags), .latch_go(latch_go), .rdata(rdata)
  );
endmodule

// File: rtl/cbt_checker.sv
module cbt_checker #(
  parameter int NCH = 4,
  parameter int CW  = 16,
  parameter int PW  = 8,
  parameter int AW  = 5
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   buf_en,
  input logic                   sat_mode,
  input logic                   latch_go,
  input logic [AW-1:0]          addr,
  input logic [CW-1:0]          rdata,
  input logic [NCH-1:0]         flag_set,
  input logic [NCH-1:0]         flags,
  input logic [NCH-1:0]         hold_load,
  input logic [NCH-1:0][CW-1:0] cap,
  input logic [NCH-1:0][CW-1:0] cap_hold,
  input logic [NCH-1:0][PW-1:0] pacc,
  input logic [NCH-1:0][PW-1:0] pacc_hold
);
  // R10
  cmd_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == '0) |-> !rdata[4]);

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    // R9
    flag_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag_set[i] |=> flags[i]);
    // R3
    hold_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !buf_en |=> ($stable(cap_hold[i]) && $stable(pacc_hold[i])));
    // R4
    queue_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold_load[i] |=> cap_hold[i] == $past(cap[i]));
    // R5
    latch_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      latch_go |=> (cap_hold[i] == $past(cap[i]) && pacc_hold[i] == $past(pacc[i])));
    // R8
    pacc_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sat_mode && pacc[i] == {PW{1'b1}} && !latch_go) |=> pacc[i] == {PW{1'b1}});
  end
endmodule

bind cap_buf_timer cbt_checker #(.NCH(NCH), .CW(CW), .PW(PW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .buf_en(buf_en), .sat_mode(sat_mode),
  .latch_go(latch_go), .addr(addr), .rdata(rdata), .flag_set(flag_set),
  .flags(flags), .hold_load(hold_load), .cap(cap), .cap_hold(cap_hold),
  .pacc(pacc), .pacc_hold(pacc_hold)
);

// File: tb/cap_buf_timer_test.sv
module cap_buf_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  pin_in = '0;
  logic        wr_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic [15:0] m_cap [4];
  logic [15:0] m_hold[4];
  logic [7:0]  m_pacc[4];
  logic [7:0]  m_phld[4];
  bit          m_full[4];
  logic [3:0]  m_flags;
  bit          m_buf, m_lat, m_fm, m_sat;
  logic [7:0]  m_esel;

  cap_buf_timer uut (.clk(clk), .rst_n(rst_n), .pin_in(pin_in), .wr_en(wr_en),
                     .addr(addr), .wdata(wdata), .rdata(rdata));

  always #5 clk = ~clk;

  function automatic bit tb_edge(input logic [1:0] s, input logic o, input logic n);
    return (s[0] && !o && n) || (s[1] && o && !n);
  endfunction

  function automatic logic [7:0] tb_inc(input logic [7:0] v, input bit s);
    return (s && v == 8'hFF) ? v : v + 8'd1;
  endfunction

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic rd(input int a, output logic [15:0] v);
    @(negedge clk);
    addr = 5'(a);
    #1 v = rdata;
  endtask

  task automatic check(input int a, input logic [15:0] exp, input string tag);
    logic [15:0] v;
    rd(a, v);
    n_cmp++;
    if (v !== exp) begin
      n_bad++;
      $display("FAIL %s addr %0d actual %h expected %h", tag, a, v, exp);
    end
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk);
    addr = 5'(a); wdata = d; wr_en = 1'b1;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic check_all();
    check(0, {12'd0, m_sat, m_fm, m_lat, m_buf}, "R10");
    check(1, {8'd0, m_esel}, "R2");
    check(2, {12'd0, m_flags}, "R6");
    for (int i = 0; i < 4; i++) begin
      check(4 + i,  m_cap[i], "R2");
      check(8 + i,  m_hold[i], "R4");
      check(12 + i, {8'd0, m_pacc[i]}, "R8");
      check(16 + i, {8'd0, m_phld[i]}, "R5");
    end
  endtask

  task automatic set_ctrl(input bit b, input bit l, input bit f, input bit s);
    wr(0, {12'd0, s, f, l, b});
    m_buf = b; m_lat = l; m_fm = f; m_sat = s;
    if (!(b && !l)) for (int i = 0; i < 4; i++) m_full[i] = 0;
  endtask

  task automatic latch_cmd();
    wr(0, {11'd0, 1'b1, m_sat, m_fm, m_lat, m_buf});
    if (m_buf && m_lat)
      for (int i = 0; i < 4; i++) begin
        m_hold[i] = m_cap[i]; m_phld[i] = m_pacc[i]; m_pacc[i] = 8'd0;
      end
  endtask

  // model the edges caused by pins changing to np; returns after settling
  task automatic move_pins(input logic [3:0] np, input bit settle);
    logic [15:0] c;
    bit q, h, ld;
    rd(3, c);
    q = m_buf && !m_lat;
    for (int i = 0; i < 4; i++) begin
      h = tb_edge(m_esel[2*i +: 2], pin_in[i], np[i]);
      if (h) begin
        ld = q && m_full[i];
        if (ld) m_hold[i] = m_cap[i];
        m_cap[i] = c + 16'd2;
        if (q) m_full[i] = 1;
        m_pacc[i] = tb_inc(m_pacc[i], m_sat);
        if (!(m_fm && q) || ld) m_flags[i] = 1'b1;
      end
    end
    pin_in = np;
    if (settle) repeat (4) @(posedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [15:0] c0, c1;
    void'($urandom(32'd4242));
    for (int i = 0; i < 4; i++) begin
      m_cap[i] = 0; m_hold[i] = 0; m_pacc[i] = 0; m_phld[i] = 0; m_full[i] = 0;
    end
    m_flags = 0; m_buf = 0; m_lat = 0; m_fm = 0; m_sat = 0; m_esel = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset values and counter stepping
    check_all();
    rd(3, c0); rd(3, c1);
    n_cmp++;
    if (c1 !== c0 + 16'd1) begin
      n_bad++; $display("FAIL R1 counter step actual %h expected %h", c1, c0 + 16'd1);
    end

    // R2: rising-only select ignores falling edge
    wr(1, 16'h00FF); m_esel = 8'hFF;
    wr(1, 16'h0001); m_esel = 8'h01;
    move_pins(4'b0001, 1); check(4, m_cap[0], "R2");
    move_pins(4'b0000, 1); check(4, m_cap[0], "R2");
    check(12, {8'd0, m_pacc[0]}, "R2");
    wr(2, 16'h000F); m_flags = 0;

    // R3: buffering off, latch command has no effect
    wr(1, 16'h00FF); m_esel = 8'hFF;
    set_ctrl(0, 1, 0, 0);
    move_pins(4'b1111, 1);
    latch_cmd();
    repeat (2) @(posedge clk);
    for (int i = 0; i < 4; i++) check(8 + i, 16'd0, "R3");
    check(16, 16'd0, "R3");

    // R4 / R7: queue mode with flag on hold load only
    wr(2, 16'h000F); m_flags = 0;
    set_ctrl(1, 0, 1, 0);
    move_pins(4'b0000, 1);
    check(2, 16'h0000, "R7");
    check(8, m_hold[0], "R4");
    move_pins(4'b1111, 1);
    check(2, 16'h000F, "R7");
    check(8, m_hold[0], "R4");

    // R9: clear write coinciding with a set event
    wr(2, 16'h000F); m_flags = 0;
    set_ctrl(1, 0, 0, 0);
    move_pins(4'b1110, 0);
    @(posedge clk); @(posedge clk);
    wr(2, 16'h0001);
    m_flags = 4'b0001;
    repeat (2) @(posedge clk);
    check(2, 16'h0001, "R9");
    wr(2, 16'h0001); m_flags = 0;
    check(2, 16'h0000, "R9");

    // R5: latch snapshot
    set_ctrl(1, 1, 0, 0);
    latch_cmd();
    check(0, 16'h0003, "R10");
    check_all();

    // R8: wrap after 256 edges
    set_ctrl(0, 0, 0, 0);
    wr(1, 16'h0003); m_esel = 8'h03;
    for (int k = 0; k < 257; k++) move_pins(pin_in ^ 4'b0001, 1);
    check(12, {8'd0, m_pacc[0]}, "R8");
    // R8: saturation
    set_ctrl(0, 0, 0, 1);
    for (int k = 0; k < 260; k++) move_pins(pin_in ^ 4'b0001, 1);
    check(12, 16'h00FF, "R8");

    // random phase
    for (int it = 0; it < 300; it++) begin
      case ($urandom % 8)
        0: begin
             logic [3:0] r = 4'($urandom);
             set_ctrl(r[0], r[1], r[2], r[3]);
           end
        1: begin m_esel = 8'($urandom); wr(1, {8'd0, m_esel}); end
        2: begin
             logic [3:0] r = 4'($urandom);
             wr(2, {12'd0, r}); m_flags = m_flags & ~r;
           end
        3: latch_cmd();
        default: move_pins(4'($urandom), 1);
      endcase
      repeat (2) @(posedge clk);
      if (it % 10 == 0) check_all();
      else begin
        check(2, {12'd0, m_flags}, "R6");
        check(4 + it % 4, m_cap[it % 4], "R2");
        check(8 + it % 4, m_hold[it % 4], "R4");
      end
    end
    check_all();
    summary();
  end
endmodule